// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer clocked by a slow-clock strobe. A 16-bit key register controls it. No single control bit can unlock its configuration, start it or feed it. Each of those actions needs one exact 16-bit key value. This makes a stray or corrupted write unlikely to change how the watchdog behaves.

A selectable prescaler divides the slow strobe. Each divided tick decrements a 12-bit down counter. When the counter is already at zero, the next tick raises a reset pulse that lasts one clock cycle. The counter then reloads and keeps running. Software feeds the watchdog by writing the feed key before that happens. A strap input can start the watchdog directly out of reset.

Configuration uses a simple register write port and a combinational read port:

| Address | Register | Access |
|---|---|---|
| 0 | key | write |
| 1 | prescaler code, bits 2:0 | read/write |
| 2 | reload value, bits 11:0 | read/write |
| 3 | status | read |

Address 0 reads back as zero. There is no valid/ready handshake: every write with `wr_en` high completes in the cycle where it is sampled. The write port can therefore never be back-pressured.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `wdt_rst` is low, the prescaler code reads 0, the reload value reads 0xFFF, the status reads 0 and the watchdog is stopped.
- R2: Writing key 0x5555 unlocks configuration. Writes to address 1 (prescaler) and address 2 (reload) take effect only while the watchdog is unlocked; otherwise the stored value stays unchanged.
- R3: Writing any other value to the key register locks configuration again. This includes 0x0000, the feed key and the start key.
- R4: Key 0xCCCC starts the watchdog and loads the counter from the reload register.
- R5: Key 0xAAAA loads the counter from the reload register and restarts the prescaler phase.
- R6: After a start or feed, the reset pulse comes after D×(RL+1) slow ticks. D is the division factor, 4 shifted left by the prescaler code, with codes 6 and 7 both giving 256. RL is the reload value.
- R7: The reset pulse lasts exactly one clock cycle. The counter then reloads and fires again after another D×(RL+1) slow ticks if it is not fed.
- R8: Once started, no key value stops the watchdog. Only `rst_n` returns it to the stopped state.
- R9: With `hw_start` high, the watchdog starts counting on the first clock after reset, using the reset values of the prescaler code and reload value.
- R10: Status bit 0 is the prescaler-update busy flag and status bit 1 is the reload-update busy flag. An accepted write sets the matching bit. The bit clears after 3 slow ticks.
- R11: A stopped watchdog never raises `wdt_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_start | input | 1 | Strap that starts the watchdog without a key write |
| slow_tick | input | 1 | One-cycle strobe from the slow clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Combinational read data |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions check several properties on every cycle:
- the reset pulse is one cycle wide and the counter holds the reload value right after it;
- the running state never drops;
- a stopped watchdog stays silent;
- configuration never changes while locked, and only the unlock key opens it;
- an accepted write raises its busy flag.

Only the bench scenarios can show the exact timeout lengths across prescaler codes and reload values. The same holds for the restart of timing on a feed, the strap start after reset, and the clearing of the busy flags after a set number of slow ticks.

// File: rtl/kwdg_pkg.sv
package kwdg_pkg;
  localparam int KEY_W  = 16;
  localparam int PSC_W  = 3;
  localparam int PDIV_W = 8;

  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;

  typedef enum logic [1:0] {
    SEL_KEY = 2'd0,
    SEL_PSC = 2'd1,
    SEL_RLD = 2'd2,
    SEL_STS = 2'd3
  } reg_sel_e;

  // Terminal value of the prescaler phase counter: division minus one.
  function automatic logic [PDIV_W-1:0] psc_terminal(input logic [PSC_W-1:0] code);
    if (code >= 3'd6) return {PDIV_W{1'b1}};
    return (PDIV_W'(4) << code) - PDIV_W'(1);
  endfunction
endpackage

// File: rtl/kwdg_keyctl.sv
module kwdg_keyctl
  import kwdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_start,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  output logic             unlocked,
  output logic             running,
  output logic             load_cnt
);
  logic unlocked_q, running_q;
  logic is_start, is_feed;

  assign is_start = key_wr && (key_val == KEY_START);
  assign is_feed  = key_wr && (key_val == KEY_FEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      running_q  <= 1'b0;
    end else begin
      if (key_wr) unlocked_q <= (key_val == KEY_UNLOCK);
      running_q <= running_q | hw_start | is_start;
    end
  end

  assign unlocked = unlocked_q;
  assign running  = running_q;
  assign load_cnt = is_start | is_feed;

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |=> running_q);  // R8
  AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> ($past(key_wr) && $past(key_val) == KEY_UNLOCK));  // R2
endmodule

// File: rtl/kwdg_cfgregs.sv
module kwdg_cfgregs
  import kwdg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int BUSY_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             unlocked,
  input  logic             wr_psc,
  input  logic             wr_rld,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] rld_in,
  output logic [PSC_W-1:0] psc_code,
  output logic [CNT_W-1:0] reload_val,
  output logic [1:0]       busy
);
  localparam int BW = $clog2(BUSY_TICKS + 1);

  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] rld_q;
  logic [1:0]       accept;

  assign accept[0] = wr_psc && unlocked;
  assign accept[1] = wr_rld && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      rld_q <= '1;
    end else begin
      if (accept[0]) psc_q <= psc_in;
      if (accept[1]) rld_q <= rld_in;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_busy
    logic [BW-1:0] bcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bcnt <= '0;
      else if (accept[i])               bcnt <= BW'(BUSY_TICKS);
      else if (slow_tick && bcnt != '0) bcnt <= bcnt - BW'(1);
    end
    assign busy[i] = (bcnt != '0);

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      accept[i] |=> busy[i]);  // R10
  end

  assign psc_code   = psc_q;
  assign reload_val = rld_q;

  AST_LOCKED_PSC: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(psc_q));  // R2
  AST_LOCKED_RLD: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(rld_q));  // R2
endmodule

// File: rtl/kwdg_prescaler.sv
module kwdg_prescaler
  import kwdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             slow_tick,
  input  logic [PSC_W-1:0] psc_code,
  output logic             dec_tick
);
  logic [PDIV_W-1:0] phase_q;
  logic [PDIV_W-1:0] term;

  assign term     = psc_terminal(psc_code);
  assign dec_tick = run && slow_tick && !restart && (phase_q >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (!run || restart) phase_q <= '0;
    else if (slow_tick)      phase_q <= dec_tick ? '0 : phase_q + PDIV_W'(1);
  end
endmodule

// File: rtl/kwdg_downcnt.sv
module kwdg_downcnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec_tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      fire_q <= 1'b0;
    end else begin
      fire_q <= dec_tick && at_zero && !load;
      if (load)          cnt_q <= reload_val;
      else if (dec_tick) cnt_q <= at_zero ? reload_val : cnt_q - CNT_W'(1);
    end
  end

  assign fire = fire_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);  // R7
  AST_FIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (cnt_q == $past(reload_val)));  // R7
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwdg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int BUSY_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_start,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        wdt_rst
);
  logic             unlocked, running, load_cnt, dec_tick;
  logic [PSC_W-1:0] psc_code;
  logic [CNT_W-1:0] reload_val;
  logic [1:0]       busy;
  logic             key_wr, psc_wr, rld_wr;

  assign key_wr = wr_en && (wr_addr == SEL_KEY);
  assign psc_wr = wr_en && (wr_addr == SEL_PSC);
  assign rld_wr = wr_en && (wr_addr == SEL_RLD);

  kwdg_keyctl u_keyctl (
    .clk(clk), .rst_n(rst_n), .hw_start(hw_start),
    .key_wr(key_wr), .key_val(wr_data),
    .unlocked(unlocked), .running(running), .load_cnt(load_cnt)
  );

  kwdg_cfgregs #(.CNT_W(CNT_W), .BUSY_TICKS(BUSY_TICKS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .unlocked(unlocked),
    .wr_psc(psc_wr), .wr_rld(rld_wr),
    .psc_in(wr_data[PSC_W-1:0]), .rld_in(wr_data[CNT_W-1:0]),
    .psc_code(psc_code), .reload_val(reload_val), .busy(busy)
  );

  kwdg_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(load_cnt),
    .slow_tick(slow_tick), .psc_code(psc_code), .dec_tick(dec_tick)
  );

  kwdg_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_cnt), .dec_tick(dec_tick),
    .reload_val(reload_val), .fire(wdt_rst)
  );

  always_comb begin
    case (rd_addr)
      SEL_PSC: rd_data = {{(16-PSC_W){1'b0}}, psc_code};
      SEL_RLD: rd_data = {{(16-CNT_W){1'b0}}, reload_val};
      SEL_STS: rd_data = {14'd0, busy};
      default: rd_data = '0;
    endcase
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wdt_rst);  // R11
endmodule

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_start = 1'b0;
  logic        slow_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        wdt_rst;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  keyed_wdog dut (
    .clk(clk), .rst_n(rst_n), .hw_start(hw_start), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst(wdt_rst)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int exp_timeout(input int code, input int rl);
    int d;
    d = (code >= 6) ? 256 : (4 << code);
    return d * (rl + 1);
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // Counts rising edges until wdt_rst is seen; returns -1 if limit passes.
  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); #1;
      n++;
      if (wdt_rst) return;
    end
    n = -1;
  endtask

  task automatic configure(input int code, input int rl);
    reg_write(2'd0, 16'h5555);
    reg_write(2'd1, 16'(code));
    reg_write(2'd2, 16'(rl));
  endtask

  initial begin
    int v, n, code, rl;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 wdt_rst", int'(wdt_rst), 0);
    reg_read(2'd1, v); check_eq("R1 prescaler", v, 0);
    reg_read(2'd2, v); check_eq("R1 reload", v, 'hFFF);
    reg_read(2'd3, v); check_eq("R1 status", v, 0);

    // R2 locked writes ignored
    reg_write(2'd1, 16'd5);
    reg_read(2'd1, v); check_eq("R2 locked prescaler write", v, 0);
    reg_write(2'd2, 16'd7);
    reg_read(2'd2, v); check_eq("R2 locked reload write", v, 'hFFF);

    // R2 + R10 unlocked write and busy flags
    reg_write(2'd0, 16'h5555);
    reg_write(2'd1, 16'd1);
    reg_read(2'd1, v); check_eq("R2 unlocked prescaler write", v, 1);
    reg_read(2'd3, v); check_eq("R10 prescaler busy set", v, 1);
    repeat (4) @(negedge clk);
    reg_read(2'd3, v); check_eq("R10 prescaler busy clear", v, 0);
    reg_write(2'd2, 16'd9);
    reg_read(2'd3, v); check_eq("R10 reload busy set", v, 2);
    repeat (4) @(negedge clk);
    reg_read(2'd3, v); check_eq("R10 reload busy clear", v, 0);

    // R3 other key relocks
    reg_write(2'd0, 16'h1234);
    reg_write(2'd1, 16'd5);
    reg_read(2'd1, v); check_eq("R3 relock by arbitrary key", v, 1);
    reg_write(2'd0, 16'h5555);
    reg_write(2'd0, 16'h0000);
    reg_write(2'd2, 16'd2);
    reg_read(2'd2, v); check_eq("R3 relock by zero key", v, 9);

    // R11 stopped watchdog silent
    wait_pulse(300, n);
    check_eq("R11 no pulse while stopped", n, -1);

    // R4 + R6 start
    configure(0, 3);
    reg_write(2'd0, 16'hCCCC);
    wait_pulse(2000, n);
    check_eq("R4 R6 start timeout", n, exp_timeout(0, 3));
    // R7 single pulse then rerun
    @(posedge clk); #1;
    check_eq("R7 pulse one cycle", int'(wdt_rst), 0);
    wait_pulse(2000, n);
    check_eq("R7 period after reload", n + 1, exp_timeout(0, 3));

    // R5 feed restarts timing, and R3 feed key relocks
    repeat (5) @(negedge clk);
    reg_write(2'd0, 16'hAAAA);
    wait_pulse(2000, n);
    check_eq("R5 feed restart", n, exp_timeout(0, 3));
    reg_write(2'd1, 16'd4);
    reg_read(2'd1, v); check_eq("R3 relock by feed key", v, 0);

    // R8 no key stops it
    reg_write(2'd0, 16'h0000);
    reg_write(2'd0, 16'h5555);
    reg_write(2'd0, 16'hFFFF);
    wait_pulse(100, n);
    check_eq("R8 still running", int'(n > 0), 1);

    // R6 large division codes
    configure(7, 0);
    reg_write(2'd0, 16'hAAAA);
    wait_pulse(2000, n);
    check_eq("R6 code 7", n, exp_timeout(7, 0));
    configure(6, 1);
    reg_write(2'd0, 16'hAAAA);
    wait_pulse(2000, n);
    check_eq("R6 code 6", n, exp_timeout(6, 1));

    // R6 random settings
    for (int k = 0; k < 8; k++) begin
      code = int'($urandom % 4);
      rl = int'($urandom % 24);
      configure(code, rl);
      reg_write(2'd0, 16'hAAAA);
      wait_pulse(3000, n);
      check_eq("R6 random timeout", n, exp_timeout(code, rl));
    end

    // R9 strap start with reset values
    @(negedge clk);
    rst_n = 1'b0; hw_start = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    wait_pulse(20000, n);
    check_eq("R9 strap start timeout", n, exp_timeout(0, 'hFFF) + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule